// File: doc/BRIEF.md
# DMA Word-Transfer Mode Controller

This block is the transfer-mode unit of a graphics controller. Software programs a word count and a base address. It then writes a 2-bit mode field. From then on, every word the host delivers on a one-cycle data strobe goes to one of two places. In memory-target mode each word goes to the frame-memory write port, and the address steps up by one after every word. In register-target mode each word goes to one fixed data-entry register, and no address moves.

When the mode starts, the block loads an internal remaining-count from the programmed word count. It takes one off that count for every word it accepts. When the count runs out, the mode field returns to normal by itself. While either DMA mode is active, a status flag is set and the grant that lets the host reach frame memory directly is withdrawn. Software can poll the flag to see when a transfer has begun and when it has finished.

Top module: `dma_word_ctrl`

## Requirements
- R1: After reset the mode field reads 00 (normal), the DMA flag is 0, the host memory grant is 1 and neither write port strobes.
- R2: Writing mode 01 or 11 (register select 0, data bits [1:0]) from normal with a nonzero count makes the mode field read the written code, sets the DMA flag and drops the host memory grant from the next cycle.
- R3: In mode 01 each accepted word produces one frame-memory write in the cycle after its strobe, carrying the word. The address starts at the base register (select 2) and rises by one, modulo 2^ADDR_W, per word.
- R4: In mode 11 each accepted word produces one data-entry write in the cycle after its strobe, and the frame-memory write strobe stays low.
- R5: The clock edge that accepts the last counted word returns the mode field to 00, clears the DMA flag and restores the host memory grant.
- R6: A mode write of the prohibited code 10 is ignored, and the mode field keeps its previous value.
- R7: Starting a DMA mode while the word-count register (select 1) holds 0 leaves the block in normal mode, with the flag clear and no word written.
- R8: Writing the word-count register during an active transfer does not change that transfer's length. The new value is used by the next start.
- R9: Data strobes in normal mode produce no write on either port.
- R10: While a DMA mode is active, every mode write is ignored, including 00 and the other DMA code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host register write strobe |
| regSel | input | 2 | Register select: 0 mode, 1 word count, 2 base address |
| regWrData | input | DATA_W | Host register write data |
| dataStrobe | input | 1 | One-cycle strobe for a DMA data word |
| dataIn | input | DATA_W | DMA data word |
| modeOut | output | 2 | Current mode field |
| dmaFlag | output | 1 | Status flag, high while a DMA mode is active |
| hostMemGrant | output | 1 | High when the host may access frame memory directly |
| memWrEn | output | 1 | Frame-memory write strobe |
| memWrAddr | output | ADDR_W | Frame-memory write address |
| memWrData | output | DATA_W | Frame-memory write data |
| entryWrEn | output | 1 | Data-entry register write strobe |
| entryWrData | output | DATA_W | Data-entry register write data |

## Verification
The main function is driven three ways. First, a short memory-target burst has a pause in the middle, during which the count register is rewritten. This separates the live remaining-count from the programmed count. Second, a longer register-target burst of back-to-back strobes checks that the second target ignores the address, and that the new count really took effect. Third, a two-word memory burst based at the top address checks that the address wraps, and it is interleaved with mode writes that must be ignored. Around these, strobes in normal mode, a zero count and the prohibited code are each shown to leave the ports unchanged.

// File: rtl/dma_word_pkg.sv
package dma_word_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_MEM    = 2'b01,
    MODE_BAD    = 2'b10,
    MODE_REG    = 2'b11
  } mode_e;

  typedef struct packed {
    logic startXfer;
    logic takeWord;
    logic regTarget;
  } dp_ctrl_s;

  localparam logic [1:0] SEL_MODE  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_BASE  = 2'd2;

endpackage

// File: rtl/dma_word_ctrl_fsm.sv
module dma_word_ctrl_fsm
  import dma_word_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWrEn,
  input  logic [1:0] modeWrData,
  input  logic       dataStrobe,
  input  logic       countZero,
  input  logic       lastWord,
  output mode_e      modeQ,
  output dp_ctrl_s   ctrl
);

  mode_e modeNext;
  mode_e reqMode;
  logic  active;
  logic  validReq;

  always_comb begin
    active   = (modeQ != MODE_NORMAL);
    reqMode  = mode_e'(modeWrData);
    validReq = (reqMode == MODE_MEM) || (reqMode == MODE_REG);

    ctrl.startXfer = !active && modeWrEn && validReq && !countZero;
    ctrl.takeWord  = active && dataStrobe;
    ctrl.regTarget = (modeQ == MODE_REG);

    modeNext = modeQ;
    if (ctrl.startXfer) begin
      modeNext = reqMode;
    end else if (ctrl.takeWord && lastWord) begin
      modeNext = MODE_NORMAL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_NORMAL;
    end else begin
      modeQ <= modeNext;
    end
  end

endmodule

// File: rtl/dma_word_datapath.sv
module dma_word_datapath
  import dma_word_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              countWrEn,
  input  logic              baseWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] dataIn,
  input  dp_ctrl_s          ctrl,
  output logic              countZero,
  output logic              lastWord,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              entryWrEn,
  output logic [DATA_W-1:0] entryWrData
);

  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [CNT_W-1:0]  countReg;
  logic [ADDR_W-1:0] baseReg;
  logic [CNT_W-1:0]  remaining;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wordQ;

  assign countZero = (countReg == '0);
  assign lastWord  = (remaining == CNT_ONE);

  // programmed registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= '0;
      baseReg  <= '0;
    end else begin
      if (countWrEn) countReg <= regWrData[CNT_W-1:0];
      if (baseWrEn)  baseReg  <= regWrData[ADDR_W-1:0];
    end
  end

  // live transfer state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= '0;
      addrQ     <= '0;
    end else if (ctrl.startXfer) begin
      remaining <= countReg;
      addrQ     <= baseReg;
    end else if (ctrl.takeWord) begin
      remaining <= remaining - CNT_ONE;
      if (!ctrl.regTarget) addrQ <= addrQ + ADDR_ONE;
    end
  end

  // write issue stage, one cycle after the strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWrEn   <= 1'b0;
      entryWrEn <= 1'b0;
      memWrAddr <= '0;
      wordQ     <= '0;
    end else begin
      memWrEn   <= ctrl.takeWord && !ctrl.regTarget;
      entryWrEn <= ctrl.takeWord && ctrl.regTarget;
      if (ctrl.takeWord) begin
        memWrAddr <= addrQ;
        wordQ     <= dataIn;
      end
    end
  end

  assign memWrData   = wordQ;
  assign entryWrData = wordQ;

endmodule

// File: rtl/dma_word_ctrl.sv
module dma_word_ctrl
  import dma_word_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              dataStrobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic [1:0]        modeOut,
  output logic              dmaFlag,
  output logic              hostMemGrant,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              entryWrEn,
  output logic [DATA_W-1:0] entryWrData
);

  mode_e    modeQ;
  dp_ctrl_s ctrl;
  logic     countZero;
  logic     lastWord;
  logic     modeWrEn;
  logic     countWrEn;
  logic     baseWrEn;

  assign modeWrEn  = regWrEn && (regSel == SEL_MODE);
  assign countWrEn = regWrEn && (regSel == SEL_COUNT);
  assign baseWrEn  = regWrEn && (regSel == SEL_BASE);

  dma_word_ctrl_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .modeWrEn   (modeWrEn),
    .modeWrData (regWrData[1:0]),
    .dataStrobe (dataStrobe),
    .countZero  (countZero),
    .lastWord   (lastWord),
    .modeQ      (modeQ),
    .ctrl       (ctrl)
  );

  dma_word_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .countWrEn   (countWrEn),
    .baseWrEn    (baseWrEn),
    .regWrData   (regWrData),
    .dataIn      (dataIn),
    .ctrl        (ctrl),
    .countZero   (countZero),
    .lastWord    (lastWord),
    .memWrEn     (memWrEn),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData),
    .entryWrEn   (entryWrEn),
    .entryWrData (entryWrData)
  );

  assign modeOut      = modeQ;
  assign dmaFlag      = (modeQ != MODE_NORMAL);
  assign hostMemGrant = (modeQ == MODE_NORMAL);

endmodule

// File: rtl/dma_word_ctrl_chk.sv
module dma_word_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              dataStrobe,
  input logic [1:0]        modeOut,
  input logic              dmaFlag,
  input logic              hostMemGrant,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic              entryWrEn
);

  assert_grant_lock_R2: assert property (@(posedge clk) disable iff (!rstN)
    dmaFlag |-> !hostMemGrant);

  assert_mem_follows_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(dataStrobe));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |-> (memWrAddr == ADDR_W'($past(memWrAddr) + 1'b1)));

  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && entryWrEn));

  assert_self_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dmaFlag) |-> $past(dataStrobe));

  assert_no_bad_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    modeOut != 2'b10);

  assert_idle_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaFlag && dataStrobe) |=> (!memWrEn && !entryWrEn));

endmodule

bind dma_word_ctrl dma_word_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .dataStrobe   (dataStrobe),
  .modeOut      (modeOut),
  .dmaFlag      (dmaFlag),
  .hostMemGrant (hostMemGrant),
  .memWrEn      (memWrEn),
  .memWrAddr    (memWrAddr),
  .entryWrEn    (entryWrEn)
);

// File: tb/dma_word_ctrl_tb.sv
`timescale 1ns/1ps
module dma_word_ctrl_tb;

  localparam int DW = 16;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [1:0]    regSel = '0;
  logic [DW-1:0] regWrData = '0;
  logic          dataStrobe = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [1:0]    modeOut;
  logic          dmaFlag;
  logic          hostMemGrant;
  logic          memWrEn;
  logic [AW-1:0] memWrAddr;
  logic [DW-1:0] memWrData;
  logic          entryWrEn;
  logic [DW-1:0] entryWrData;

  always #2 clk = ~clk;

  dma_word_ctrl #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(16)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .dataStrobe(dataStrobe), .dataIn(dataIn),
    .modeOut(modeOut), .dmaFlag(dmaFlag), .hostMemGrant(hostMemGrant),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .entryWrEn(entryWrEn), .entryWrData(entryWrData)
  );

  typedef struct {
    bit            isReg;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } exp_t;

  exp_t expQ[$];
  int   total = 0;
  int   bad   = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkState(input string req, input logic [1:0] m,
                            input logic f, input logic g);
    check(req, "mode", {30'd0, modeOut}, {30'd0, m});
    check(req, "flag", {31'd0, dmaFlag}, {31'd0, f});
    check(req, "grant", {31'd0, hostMemGrant}, {31'd0, g});
  endtask

  // all driver tasks start and end at a falling edge
  task automatic regWrite(input logic [1:0] sel, input logic [DW-1:0] d);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic sendWord(input logic [DW-1:0] d, input bit expectWr,
                          input bit isReg, input logic [AW-1:0] a);
    exp_t e;
    if (expectWr) begin
      e.isReg = isReg; e.addr = a; e.data = d;
      expQ.push_back(e);
    end
    dataStrobe = 1'b1; dataIn = d;
    @(negedge clk);
    dataStrobe = 1'b0;
  endtask

  // monitor: pops one expected item per observed write
  always @(negedge clk) begin
    exp_t e;
    if (rstN && (memWrEn || entryWrEn)) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R9 unexpected write actual=mem%0b/entry%0b expected=none",
                 memWrEn, entryWrEn);
      end else begin
        e = expQ.pop_front();
        if (e.isReg) begin
          check("R4", "entryWrEn", {31'd0, entryWrEn}, 32'd1);
          check("R4", "memWrEn", {31'd0, memWrEn}, 32'd0);
          check("R4", "entryData", {16'd0, entryWrData}, {16'd0, e.data});
        end else begin
          check("R3", "memWrEn", {31'd0, memWrEn}, 32'd1);
          check("R3", "entryWrEn", {31'd0, entryWrEn}, 32'd0);
          check("R3", "memAddr", {16'd0, memWrAddr}, {16'd0, e.addr});
          check("R3", "memData", {16'd0, memWrData}, {16'd0, e.data});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkState("R1", 2'b00, 1'b0, 1'b1);
    check("R1", "writes", {30'd0, memWrEn, entryWrEn}, 32'd0);

    // R9 strobes in normal mode
    sendWord(16'hAAAA, 0, 0, '0);
    sendWord(16'hBBBB, 0, 0, '0);
    check("R9", "writes", {30'd0, memWrEn, entryWrEn}, 32'd0);

    // R2/R3/R8/R5 memory target, count 3, base 0x100
    regWrite(2'd2, 16'h0100);
    regWrite(2'd1, 16'd3);
    regWrite(2'd0, 16'h0001);
    checkState("R2", 2'b01, 1'b1, 1'b0);
    sendWord(16'h1111, 1, 0, 16'h0100);
    sendWord(16'h2222, 1, 0, 16'h0101);
    regWrite(2'd1, 16'd7);
    checkState("R8", 2'b01, 1'b1, 1'b0);
    sendWord(16'h3333, 1, 0, 16'h0102);
    checkState("R5", 2'b00, 1'b0, 1'b1);
    sendWord(16'h4444, 0, 0, '0);
    @(negedge clk);
    check("R3", "queue empty", expQ.size(), 32'd0);

    // R4/R8 register target, uses the count 7 written mid-transfer
    regWrite(2'd0, 16'h0003);
    checkState("R2", 2'b11, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) sendWord(DW'(16'h5000 + i), 1, 1, '0);
    checkState("R8", 2'b11, 1'b1, 1'b0);
    sendWord(16'h5006, 1, 1, '0);
    checkState("R5", 2'b00, 1'b0, 1'b1);
    @(negedge clk);
    check("R4", "queue empty", expQ.size(), 32'd0);

    // R6 prohibited code from normal
    regWrite(2'd0, 16'h0002);
    checkState("R6", 2'b00, 1'b0, 1'b1);

    // R6/R10 ignored mode writes while active; R3 address wrap
    regWrite(2'd1, 16'd2);
    regWrite(2'd2, 16'hFFFF);
    regWrite(2'd0, 16'h0001);
    regWrite(2'd0, 16'h0002);
    checkState("R6", 2'b01, 1'b1, 1'b0);
    regWrite(2'd0, 16'h0003);
    checkState("R10", 2'b01, 1'b1, 1'b0);
    regWrite(2'd0, 16'h0000);
    checkState("R10", 2'b01, 1'b1, 1'b0);
    sendWord(16'h6001, 1, 0, 16'hFFFF);
    sendWord(16'h6002, 1, 0, 16'h0000);
    checkState("R5", 2'b00, 1'b0, 1'b1);
    @(negedge clk);
    check("R3", "queue empty", expQ.size(), 32'd0);

    // R7 zero count
    regWrite(2'd1, 16'd0);
    regWrite(2'd0, 16'h0001);
    checkState("R7", 2'b00, 1'b0, 1'b1);
    regWrite(2'd0, 16'h0003);
    checkState("R7", 2'b00, 1'b0, 1'b1);
    sendWord(16'h7777, 0, 0, '0);
    check("R7", "writes", {30'd0, memWrEn, entryWrEn}, 32'd0);

    // single-word register transfer
    regWrite(2'd1, 16'd1);
    regWrite(2'd0, 16'h0003);
    sendWord(16'h8888, 1, 1, '0);
    checkState("R5", 2'b00, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    check("R4", "queue empty", expQ.size(), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule